// File: doc/BRIEF.md
# Register-Mapped Factorial Unit

This block is a slave register file on a simple 32-bit memory-mapped bus. It has an address, a write enable, write data, an access-size field in bytes and a combinational read-data return. Software uses it to confirm that the device is present, to test the data path, and to offload a factorial computation.

Four registers are decoded in the low window:
- an identification word that software can only read;
- a liveness word that reads back the bitwise inverse of its last write;
- an operand register that also receives the result;
- a status register that carries a busy flag and an interrupt-enable bit.

Writing the operand register while the unit is idle starts a sequential engine. The engine performs one wrapping 32-bit multiply per clock. When the result is ready it overwrites the operand.

If the interrupt enable is set, the block emits a one-cycle interrupt-raise pulse with a fixed code in the last busy cycle. An interrupt controller outside the block collects the pulse. The engine is a three-state machine:
- `ST_IDLE`: waits for a start.
- `ST_MULT`: multiplies the accumulator by a down-counter.
- `ST_FINISH`: the final busy cycle, in which the result is written back and the interrupt pulse is emitted.

It has four transitions:
- `ST_IDLE`→`ST_MULT` on an accepted operand write.
- `ST_MULT`→`ST_MULT` while the counter is above 1.
- `ST_MULT`→`ST_FINISH` once the counter is 1 or less.
- `ST_FINISH`→`ST_IDLE` unconditionally.

Top module: `fact_unit`

## Requirements
- R1: Offset 0x00 reads {VER_MAJOR[7:0], VER_MINOR[7:0], 16'h00ED} (default 0x010000ED); writes to it change nothing.
- R2: Offset 0x04 reads the bitwise complement of the last value written there; after reset it reads 0xFFFFFFFF.
- R3: A write of n to offset 0x08 while idle stores n and starts a computation. When the computation completes, offset 0x08 reads n! modulo 2^32, where 0! and 1! are both 1.
- R4: Status (offset 0x20) bit 0 is the busy flag. It reads 1 for exactly max(n,1)+1 cycles, starting in the cycle after the accepted operand write. The result is visible in the cycle after busy drops.
- R5: Status bit 7 is a read/write interrupt enable. Writes to bit 0 and to all other status bits have no effect, and those other bits read 0.
- R6: In the last busy cycle, if the enable is set, `irq_raise` is high for that single cycle and `irq_value` reads 0x00000001. In every other cycle `irq_raise` is low and `irq_value` is zero.
- R7: A write to offset 0x08 while busy is ignored: the operand register keeps its value and the running computation is not disturbed.
- R8: An access whose `bus_size` is not 4 is ignored on writes and returns zero on reads.
- R9: Offsets other than 0x00, 0x04, 0x08 and 0x20 read zero, and writes to them change no register. This includes every offset at or above 0x80.
- R10: After reset the operand is 0, the interrupt enable is 0, the unit is idle and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (20) | Byte offset of the access |
| bus_size | input | SIZE_W (4) | Access width in bytes |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the current address and size, combinational |
| irq_raise | output | 1 | One-cycle interrupt-raise request on completion |
| irq_value | output | DATA_W (32) | Code to OR into the interrupt status, zero when idle |

## Verification
The assertions take for granted that the bus presents at most one access per cycle. They also assume `bus_addr`, `bus_size` and `bus_we` are stable around the clock edge. The bench drives these inputs only at the falling edge, so this holds. The busy-rise and liveness properties further assume that a write strobe with size 4 to a mapped offset is a real access. The stimulus therefore never pulses the strobe without also meaning a write. Operands stay small (at most 20), so each run ends within a few dozen cycles and the overflow case is still reached.

// File: rtl/fact_pkg.sv
package fact_pkg;

    // Byte offsets of the mapped registers
    localparam int unsigned OFS_ID    = 32'h00;
    localparam int unsigned OFS_LIVE  = 32'h04;
    localparam int unsigned OFS_OPND  = 32'h08;
    localparam int unsigned OFS_STAT  = 32'h20;
    // Accesses at or above this offset hit no register in this block
    localparam int unsigned OFS_LIMIT = 32'h80;

    // Status register bit positions
    localparam int unsigned STAT_BUSY_BIT = 0;
    localparam int unsigned STAT_IEN_BIT  = 7;

    // Code presented with the completion interrupt
    localparam int unsigned IRQ_CODE = 32'h1;

    // Low half of the identification word
    localparam logic [15:0] ID_TAG = 16'h00ED;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MULT   = 2'd1,
        ST_FINISH = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic id;
        logic live;
        logic opnd;
        logic stat;
    } reg_sel_t;

endpackage

// File: rtl/fact_decode.sv
module fact_decode
    import fact_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SIZE_W    = 4,
    parameter int ACC_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              we,
    output reg_sel_t          rsel,
    output reg_sel_t          wsel
);

    localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFS_ID);
    localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFS_LIVE);
    localparam logic [ADDR_W-1:0] A_OPND  = ADDR_W'(OFS_OPND);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFS_LIMIT);
    localparam logic [SIZE_W-1:0] SZ_OK   = SIZE_W'(ACC_BYTES);

    logic access_ok;

    always_comb begin
        access_ok = (size == SZ_OK) && (addr < A_LIMIT);
        rsel.id   = access_ok && (addr == A_ID);
        rsel.live = access_ok && (addr == A_LIVE);
        rsel.opnd = access_ok && (addr == A_OPND);
        rsel.stat = access_ok && (addr == A_STAT);
        wsel.id   = we && rsel.id;
        wsel.live = we && rsel.live;
        wsel.opnd = we && rsel.opnd;
        wsel.stat = we && rsel.stat;
    end

endmodule

// File: rtl/fact_engine.sv
module fact_engine
    import fact_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic              irq_en,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              irq_pulse,
    output logic [DATA_W-1:0] irq_code
);

    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] CODE = DATA_W'(IRQ_CODE);

    eng_state_t        state_q, state_d;
    logic [DATA_W-1:0] acc_q, acc_d;
    logic [DATA_W-1:0] cnt_q, cnt_d;
    logic [DATA_W-1:0] prod;
    logic              cnt_last;

    assign prod     = acc_q * cnt_q;
    assign cnt_last = (cnt_q <= ONE);

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= ONE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_MULT;
                    acc_d   = ONE;
                    cnt_d   = operand;
                end
            end
            ST_MULT: begin
                if (cnt_last) begin
                    state_d = ST_FINISH;
                end else begin
                    acc_d = prod;
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        irq_pulse = 1'b0;
        irq_code  = '0;
        result    = acc_q;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_MULT: begin
                busy = 1'b1;
            end
            ST_FINISH: begin
                busy      = 1'b1;
                done      = 1'b1;
                irq_pulse = irq_en;
                irq_code  = irq_en ? CODE : '0;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fact_regfile.sv
module fact_regfile
    import fact_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [7:0]  VER_MAJOR = 8'h01,
    parameter logic [7:0]  VER_MINOR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_t          rsel,
    input  reg_sel_t          wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] result,
    output logic              start,
    output logic              irq_en,
    output logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] live,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({VER_MAJOR, VER_MINOR, ID_TAG});

    logic [DATA_W-1:0] live_q;
    logic [DATA_W-1:0] opnd_q;
    logic              ien_q;
    logic [DATA_W-1:0] stat_word;

    assign start  = wsel.opnd && !busy;
    assign irq_en = ien_q;
    assign opnd   = opnd_q;
    assign live   = live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '1;
            opnd_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (wsel.live) begin
                live_q <= ~wdata;
            end
            if (wsel.stat) begin
                ien_q <= wdata[STAT_IEN_BIT];
            end
            if (done) begin
                opnd_q <= result;
            end else if (start) begin
                opnd_q <= wdata;
            end
        end
    end

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_BUSY_BIT] = busy;
        stat_word[STAT_IEN_BIT]  = ien_q;
    end

    always_comb begin
        rdata = '0;
        if (rsel.id) begin
            rdata = ID_WORD;
        end else if (rsel.live) begin
            rdata = live_q;
        end else if (rsel.opnd) begin
            rdata = opnd_q;
        end else if (rsel.stat) begin
            rdata = stat_word;
        end
    end

endmodule

// File: rtl/fact_unit.sv
module fact_unit
    import fact_pkg::*;
#(
    parameter int         ADDR_W    = 20,
    parameter int         DATA_W    = 32,
    parameter int         SIZE_W    = 4,
    parameter logic [7:0] VER_MAJOR = 8'h01,
    parameter logic [7:0] VER_MINOR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_raise,
    output logic [DATA_W-1:0] irq_value
);

    reg_sel_t          rsel;
    reg_sel_t          wsel;
    logic              eng_start;
    logic              eng_busy;
    logic              eng_done;
    logic              ien;
    logic [DATA_W-1:0] eng_result;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] live_q;

    fact_decode #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .ACC_BYTES (DATA_W / 8)
    ) u_decode (
        .addr (bus_addr),
        .size (bus_size),
        .we   (bus_we),
        .rsel (rsel),
        .wsel (wsel)
    );

    fact_regfile #(
        .DATA_W    (DATA_W),
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .rsel   (rsel),
        .wsel   (wsel),
        .wdata  (bus_wdata),
        .busy   (eng_busy),
        .done   (eng_done),
        .result (eng_result),
        .start  (eng_start),
        .irq_en (ien),
        .opnd   (opnd_q),
        .live   (live_q),
        .rdata  (bus_rdata)
    );

    fact_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .operand   (bus_wdata),
        .irq_en    (ien),
        .busy      (eng_busy),
        .done      (eng_done),
        .result    (eng_result),
        .irq_pulse (irq_raise),
        .irq_code  (irq_value)
    );

endmodule

// File: rtl/fact_unit_chk.sv
module fact_unit_chk #(
    parameter int         ADDR_W    = 20,
    parameter int         DATA_W    = 32,
    parameter int         SIZE_W    = 4,
    parameter logic [7:0] VER_MAJOR = 8'h01,
    parameter logic [7:0] VER_MINOR = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SIZE_W-1:0] bus_size,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_raise,
    input logic [DATA_W-1:0] irq_value,
    input logic              eng_busy,
    input logic              eng_done,
    input logic [DATA_W-1:0] opnd_q,
    input logic [DATA_W-1:0] live_q
);

    localparam logic [SIZE_W-1:0] SZ4     = SIZE_W'(4);
    localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_OPND  = ADDR_W'(8);
    localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({VER_MAJOR, VER_MINOR, 16'h00ED});

    // R1
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size == SZ4 && bus_addr == A_ID) |-> bus_rdata == ID_WORD);

    // R2
    live_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_size == SZ4 && bus_addr == A_LIVE) |=> live_q == ~$past(bus_wdata));

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(bus_we && bus_size == SZ4 && bus_addr == A_OPND));

    // R6
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |-> irq_value == DATA_W'(1));

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_raise |-> irq_value == '0);

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |=> !irq_raise);

    // R6
    irq_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |=> !eng_busy);

    // R7
    opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_done) |=> $stable(opnd_q));

    // R8
    size_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size != SZ4) |-> bus_rdata == '0);

endmodule

bind fact_unit fact_unit_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SIZE_W    (SIZE_W),
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_raise (irq_raise),
    .irq_value (irq_value),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .opnd_q    (opnd_q),
    .live_q    (live_q)
);

// File: tb/tb_fact_unit.sv
module tb_fact_unit;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] a;
    logic [3:0]    sz;
    logic          we;
    logic [31:0]   wd;
    logic [31:0]   rd;
    logic          irq;
    logic [31:0]   iv;

    always #5 clk = ~clk;

    fact_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (a),
        .bus_size  (sz),
        .bus_we    (we),
        .bus_wdata (wd),
        .bus_rdata (rd),
        .irq_raise (irq),
        .irq_value (iv)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Behavioural reference state
    logic [31:0] m_live = 32'hFFFF_FFFF;
    logic [31:0] m_op   = 32'h0;
    logic [31:0] m_res  = 32'h0;
    logic        m_en   = 1'b0;
    int          m_left = 0;

    function automatic logic [31:0] fact(logic [31:0] n);
        logic [31:0] acc = 32'd1;
        for (logic [31:0] i = 32'd2; i <= n; i++) acc = acc * i;
        return acc;
    endfunction

    function automatic logic [31:0] m_read(logic [AW-1:0] ad, logic [3:0] s);
        if (s != 4'd4 || ad >= 128) return 32'h0;
        case (ad)
            0:       return 32'h0100_00ED;
            4:       return m_live;
            8:       return m_op;
            32:      return {24'h0, m_en, 6'h0, (m_left > 0)};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag(logic [AW-1:0] ad, logic [3:0] s);
        if (s != 4'd4) return "R8";
        if (ad >= 128) return "R9";
        case (ad)
            0:       return "R1";
            4:       return "R2";
            8:       return (m_left > 0) ? "R7" : "R3";
            32:      return "R4 R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (addr %h size %0d)", req, act, exp, a, sz);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic cyc(logic [AW-1:0] ad, logic [3:0] s, logic w, logic [31:0] d);
        logic fin;
        logic was_busy;
        logic mirq;
        @(negedge clk);
        a = ad; sz = s; we = w; wd = d;
        #1;
        mirq = (m_left == 1) && m_en;
        check(tag(ad, s), rd, m_read(ad, s));
        check("R6", {31'h0, irq}, {31'h0, mirq});
        check("R6", iv, mirq ? 32'h1 : 32'h0);
        @(posedge clk);
        fin      = (m_left == 1);
        was_busy = (m_left > 0);
        if (was_busy) begin
            m_left--;
            if (fin) m_op = m_res;
        end
        if (w && s == 4'd4 && ad < 128) begin
            case (ad)
                4:  m_live = ~d;
                32: m_en = d[7];
                8: if (!was_busy) begin
                    m_op   = d;
                    m_res  = fact(d);
                    m_left = ((d > 1) ? int'(d) : 1) + 1;
                end
                default: ;
            endcase
        end
    endtask

    task automatic wr(logic [AW-1:0] ad, logic [31:0] d);
        cyc(ad, 4'd4, 1'b1, d);
    endtask

    task automatic rdc(logic [AW-1:0] ad);
        cyc(ad, 4'd4, 1'b0, 32'h0);
    endtask

    task automatic drain();
        int k = 0;
        while (m_left > 0) begin
            rdc((k % 2 == 0) ? AW'(32) : AW'(8));
            k++;
        end
        rdc(AW'(8));
    endtask

    task automatic run_fact(logic [31:0] n);
        wr(AW'(8), n);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        rst_n = 1'b0; a = '0; sz = 4'd4; we = 1'b0; wd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        a = AW'(32);
        #1;
        // R10 reset state
        check("R10", rd, 32'h0);
        check("R10", {31'h0, irq}, 32'h0);
        rdc(AW'(0)); rdc(AW'(4)); rdc(AW'(8)); rdc(AW'(32));
        rdc(AW'(12)); rdc(AW'(132));
        // R1 identification survives a write
        wr(AW'(0), 32'hFFFF_FFFF); rdc(AW'(0));
        // R2 liveness
        wr(AW'(4), 32'h1234_5678); rdc(AW'(4));
        wr(AW'(4), 32'h0); rdc(AW'(4));
        // R5 enable set, bit 0 and others ignored
        wr(AW'(32), 32'hFFFF_FFFF); rdc(AW'(32));
        // R3 R4 R6 computations with interrupt
        run_fact(32'd5);
        run_fact(32'd0);
        run_fact(32'd1);
        run_fact(32'd13);
        run_fact(32'd20);
        // R7 write while busy, enable dropped mid-run
        wr(AW'(8), 32'd6);
        wr(AW'(8), 32'd3);
        rdc(AW'(8));
        wr(AW'(32), 32'h0);
        drain();
        run_fact(32'd4);
        wr(AW'(32), 32'h80);
        // R8 size other than 4
        cyc(AW'(4), 4'd8, 1'b1, 32'hAAAA_5555);
        cyc(AW'(4), 4'd2, 1'b1, 32'h0000_FFFF);
        cyc(AW'(4), 4'd8, 1'b0, 32'h0);
        cyc(AW'(8), 4'd1, 1'b1, 32'd7);
        cyc(AW'(0), 4'd8, 1'b0, 32'h0);
        rdc(AW'(4)); rdc(AW'(32));
        // R9 unmapped offsets
        wr(AW'(12), 32'd5); wr(AW'(132), 32'hDEAD_BEEF); wr(AW'(96), 32'h1);
        rdc(AW'(36)); rdc(AW'(152)); rdc(AW'(8)); rdc(AW'(4));
        // Mixed pattern
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] ad;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0: ad = AW'(0);
                3'd1: ad = AW'(4);
                3'd2, 3'd3: ad = AW'(8);
                3'd4, 3'd5: ad = AW'(32);
                3'd6: ad = AW'(36);
                default: ad = AW'(144);
            endcase
            cyc(ad, (lf[9:8] == 2'd0) ? 4'd8 : 4'd4, lf[3] & lf[4],
                (ad == AW'(8)) ? {28'h0, lf[15:12]} : {lf, lf ^ 16'h5A5A});
        end
        drain();
        summary();
        $finish;
    end

endmodule